// File: doc/BRIEF.md
# Comparator Decision Filter and Event Detector

This block takes the raw one-bit decision of a single analog comparator channel and turns it into clean, clock-domain results. The decision is optionally inverted, to go with an input exchange done in the analog front end, then passed through a two-stage synchronizer. A selectable majority vote over the most recent synchronized samples filters it. The filtered level, or the unsynchronized decision, can be routed to an output pin. An interrupt pulse is raised on a selected edge of the filtered level, or when a single-shot comparison completes.

All configuration arrives as static inputs. The channel runs continuously or performs one comparison per start request. When a sleep input is asserted it either keeps running or shuts down, depending on a run-in-sleep control.

Top module: `cmp_result_filter`

## Requirements
- R1: With `swap_i` set, the filtered result and the raw pin path carry the inverse of `raw_i`.
- R2: With `flen_i` = 0, a change on `raw_i` reaches `result_o` on the third rising clock edge after it is applied: two synchronizer edges and one filter register edge.
- R3: With `flen_i` = 1, `result_o` is the 2-of-3 majority of the last three samples. A steady change appears on the fourth edge, and a one-cycle pulse on `raw_i` is rejected.
- R4: With `flen_i` = 2, `result_o` is the 3-of-5 majority of the last five samples. A steady change appears on the fifth edge, and a two-cycle pulse is rejected.
- R5: `flen_i` codes 3 to 7 behave exactly as code 0.
- R6: `pin_o` follows `osel_i`. Code 0 drives 0. Code 1 drives `raw_i ^ swap_i` combinationally while the channel is active. Code 2 drives `result_o`. Code 3 drives 0. After reset all outputs are 0.
- R7: With `isel_i` at 0 (any change), 1 (0-to-1) or 2 (1-to-0), `irq_o` is high for exactly the one cycle in which `result_o` shows the selected change.
- R8: With `single_i` set, a `start_i` pulse accepted while idle starts a comparison that takes N samples, where N is 1, 3 or 5 from `flen_i`. It ends on the Nth edge after the accepting edge. With `isel_i` = 3, `irq_o` then pulses for one cycle. With `single_i` clear, code 3 never raises `irq_o`.
- R9: In single-shot mode, `result_o` holds its value between comparisons, whatever `raw_i` does.
- R10: The channel is active when `enable_i` is set, and `sleep_i` is clear or `stdby_run_i` is set. While inactive, `result_o` is cleared on the next edge and `irq_o` stays 0. With `stdby_run_i` set, the filter keeps tracking during sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Channel enable |
| sleep_i | input | 1 | Sleep request |
| stdby_run_i | input | 1 | Keep running while asleep |
| raw_i | input | 1 | Unsynchronized comparator decision |
| swap_i | input | 1 | Invert decision (inputs exchanged) |
| flen_i | input | 3 | Filter length code |
| osel_i | input | 2 | Pin output source code |
| isel_i | input | 2 | Interrupt condition code |
| single_i | input | 1 | Single-shot mode |
| start_i | input | 1 | Start one comparison (single-shot) |
| result_o | output | 1 | Synchronized, filtered result |
| pin_o | output | 1 | Selected pin value |
| irq_o | output | 1 | Interrupt or event pulse |

## Verification
On every cycle, the assertions check the following. The no-filter path delivers the previous sample. An inactive channel clears its result. An idle single-shot channel holds its result. A rising-mode interrupt only accompanies a high result. The end-of-comparison marker never lasts two cycles. The bench scenarios are needed to show the exact latencies per filter length and the rejection of short pulses. They also show swap inversion, the pin source codes, each interrupt mode, and the sample count of a single-shot comparison.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int HIST_W = 5;
  localparam int WIN_W  = 3;

  localparam logic [2:0] FLEN_MAJ3 = 3'd1;
  localparam logic [2:0] FLEN_MAJ5 = 3'd2;

  localparam logic [1:0] OSEL_RAW  = 2'd1;
  localparam logic [1:0] OSEL_FILT = 2'd2;

  localparam logic [1:0] ISEL_ANY  = 2'd0;
  localparam logic [1:0] ISEL_RISE = 2'd1;
  localparam logic [1:0] ISEL_FALL = 2'd2;
  localparam logic [1:0] ISEL_EOC  = 2'd3;

  // samples per single-shot comparison; reserved codes act as no filter
  function automatic logic [WIN_W-1:0] win_len(input logic [2:0] flen);
    case (flen)
      FLEN_MAJ3: win_len = 3'd3;
      FLEN_MAJ5: win_len = 3'd5;
      default:   win_len = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    stg_q <= '0;
        else if (clr_i) stg_q <= '0;
        else            stg_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    stg_q <= '0;
        else if (clr_i) stg_q <= '0;
        else            stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cmp_maj_filter.sv
module cmp_maj_filter
  import cmp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       restart_i,
  input  logic       samp_en_i,
  input  logic       sample_i,
  input  logic [2:0] flen_i,
  output logic       filt_o
);
  logic [HIST_W-1:0] hist_q, hist_nxt;
  logic              filt_q, filt_d;

  assign hist_nxt = {hist_q[HIST_W-2:0], sample_i};

  always_comb begin
    case (flen_i)
      FLEN_MAJ3: filt_d = ($countones(hist_nxt[2:0]) >= 2);
      FLEN_MAJ5: filt_d = ($countones(hist_nxt) >= 3);
      default:   filt_d = sample_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else if (clr_i) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else if (restart_i) begin
      hist_q <= '0;
    end else if (samp_en_i) begin
      hist_q <= hist_nxt;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

  // R2 / R5: without majority the result is the sample taken at the last edge
  a_r2_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_en_i && !clr_i && !restart_i && win_len(flen_i) == 3'd1)
      |=> (filt_o == $past(sample_i)));
endmodule

// File: rtl/cmp_edge_irq.sv
module cmp_edge_irq
  import cmp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       level_i,
  input  logic [1:0] isel_i,
  input  logic       single_i,
  input  logic       eoc_i,
  output logic       irq_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prev_q <= 1'b0;
    else if (clr_i) prev_q <= 1'b0;
    else            prev_q <= level_i;
  end

  always_comb begin
    irq_o = 1'b0;
    if (!clr_i) begin
      case (isel_i)
        ISEL_ANY:  irq_o = level_i ^ prev_q;
        ISEL_RISE: irq_o = level_i & ~prev_q;
        ISEL_FALL: irq_o = ~level_i & prev_q;
        default:   irq_o = single_i & eoc_i;
      endcase
    end
  end
endmodule

// File: rtl/cmp_result_filter.sv
module cmp_result_filter
  import cmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       sleep_i,
  input  logic       stdby_run_i,
  input  logic       raw_i,
  input  logic       swap_i,
  input  logic [2:0] flen_i,
  input  logic [1:0] osel_i,
  input  logic [1:0] isel_i,
  input  logic       single_i,
  input  logic       start_i,
  output logic       result_o,
  output logic       pin_o,
  output logic       irq_o
);
  logic             active, cmp_in, sync_val;
  logic             busy_q, eoc_q, start_ok, samp_en;
  logic [WIN_W-1:0] cnt_q;

  assign active   = enable_i & (~sleep_i | stdby_run_i);
  assign cmp_in   = raw_i ^ swap_i;
  assign start_ok = active & single_i & ~busy_q & start_i;
  assign samp_en  = active & (single_i ? busy_q : 1'b1);

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~active),
    .d_i   (cmp_in),
    .q_o   (sync_val)
  );

  // single-shot sequencing: count samples of the comparison window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      eoc_q  <= 1'b0;
    end else if (!active || !single_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      eoc_q  <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      if (start_ok) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == win_len(flen_i) - 3'd1) begin
          busy_q <= 1'b0;
          eoc_q  <= 1'b1;
        end
        cnt_q <= cnt_q + 3'd1;
      end
    end
  end

  cmp_maj_filter u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (~active),
    .restart_i(start_ok),
    .samp_en_i(samp_en),
    .sample_i (sync_val),
    .flen_i   (flen_i),
    .filt_o   (result_o)
  );

  cmp_edge_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (~active),
    .level_i (result_o),
    .isel_i  (isel_i),
    .single_i(single_i),
    .eoc_i   (eoc_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    case (osel_i)
      OSEL_RAW:  pin_o = active & cmp_in;
      OSEL_FILT: pin_o = result_o;
      default:   pin_o = 1'b0;
    endcase
  end

  a_r10_inactive_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !result_o);

  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && single_i && !busy_q) |=> $stable(result_o));

  a_r7_rise_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && isel_i == ISEL_RISE) |-> result_o);

  a_r8_eoc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_q |=> !eoc_q);
endmodule

// File: tb/sim_cmp_result_filter.sv
module sim_cmp_result_filter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0, sleep_i = 1'b0, stdby_run_i = 1'b0;
  logic       raw_i = 1'b0, swap_i = 1'b0, single_i = 1'b0, start_i = 1'b0;
  logic [2:0] flen_i = 3'd0;
  logic [1:0] osel_i = 2'd0, isel_i = 2'd0;
  logic       result_o, pin_o, irq_o;

  int errors = 0;
  int checks = 0;

  always #10 clk_i = ~clk_i;

  cmp_result_filter u0 (.*);

  // {flen[2:0], swap, osel[1:0], raw, exp_result, exp_pin}
  localparam logic [8:0] VEC [8] = '{
    {3'd0, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1},
    {3'd1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0},
    {3'd2, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1},
    {3'd2, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0},
    {3'd5, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0},
    {3'd7, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0},
    {3'd1, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0},
    {3'd0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic count_irq(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk_i);
      if (irq_o) cnt++;
    end
  endtask

  task automatic chk_cnt(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    tick(3);
    chk("R6 reset result", result_o, 1'b0);
    chk("R6 reset pin", pin_o, 1'b0);
    chk("R6 reset irq", irq_o, 1'b0);
    rst_ni = 1'b1;
    enable_i = 1'b1;
    tick(2);

    // vector table, continuous mode, steady state
    for (int i = 0; i < 8; i++) begin
      {flen_i, swap_i, osel_i, raw_i} = VEC[i][8:2];
      tick(8);
      chk("R1/R5/R6 vec result", result_o, VEC[i][1]);
      chk("R1/R6 vec pin", pin_o, VEC[i][0]);
    end

    // R2 latency and R7 rising pulse
    flen_i = 3'd0; swap_i = 1'b0; osel_i = 2'd2; isel_i = 2'd1; raw_i = 1'b0;
    tick(8);
    raw_i = 1'b1;
    tick(2);
    chk("R2 before third edge", result_o, 1'b0);
    tick(1);
    chk("R2 at third edge", result_o, 1'b1);
    chk("R7 rise pulse", irq_o, 1'b1);
    tick(1);
    chk("R7 rise single cycle", irq_o, 1'b0);

    // R7 rising mode ignores falling; falling mode fires
    raw_i = 1'b0;
    count_irq(6, n);
    chk_cnt("R7 rise ignores fall", n, 0);
    isel_i = 2'd2; raw_i = 1'b1;
    tick(8);
    raw_i = 1'b0;
    tick(3);
    chk("R7 fall pulse", irq_o, 1'b1);
    chk("R7 fall result", result_o, 1'b0);
    tick(1);
    chk("R7 fall single cycle", irq_o, 1'b0);

    // R3: 2-of-3 latency and glitch rejection, toggle irq
    flen_i = 3'd1; isel_i = 2'd0; raw_i = 1'b0;
    tick(8);
    raw_i = 1'b1; tick(1); raw_i = 1'b0;
    count_irq(8, n);
    chk_cnt("R3 glitch irq", n, 0);
    chk("R3 glitch result", result_o, 1'b0);
    raw_i = 1'b1;
    tick(3);
    chk("R3 before fourth edge", result_o, 1'b0);
    tick(1);
    chk("R3 at fourth edge", result_o, 1'b1);
    chk("R7 toggle pulse", irq_o, 1'b1);

    // R4: 3-of-5
    flen_i = 3'd2; raw_i = 1'b0;
    tick(8);
    raw_i = 1'b1; tick(2); raw_i = 1'b0;
    count_irq(8, n);
    chk_cnt("R4 glitch irq", n, 0);
    chk("R4 glitch result", result_o, 1'b0);
    raw_i = 1'b1;
    tick(4);
    chk("R4 before fifth edge", result_o, 1'b0);
    tick(1);
    chk("R4 at fifth edge", result_o, 1'b1);

    // R8: end-of-comparison code in continuous mode stays silent
    isel_i = 2'd3; flen_i = 3'd0;
    for (int k = 0; k < 6; k++) begin
      raw_i = ~raw_i;
      tick(2);
    end
    count_irq(6, n);
    chk_cnt("R8 eoc silent in continuous", n, 0);

    // R9 / R8 single shot
    flen_i = 3'd1; raw_i = 1'b0;
    tick(8);
    single_i = 1'b1; raw_i = 1'b1;
    tick(8);
    chk("R9 idle holds", result_o, 1'b0);
    start_i = 1'b1; tick(1); start_i = 1'b0;
    count_irq(2, n);
    chk_cnt("R8 no early eoc", n, 0);
    tick(1);
    chk("R8 eoc pulse", irq_o, 1'b1);
    chk("R8 result after window", result_o, 1'b1);
    tick(1);
    chk("R8 eoc single cycle", irq_o, 1'b0);
    raw_i = 1'b0;
    tick(8);
    chk("R9 hold after comparison", result_o, 1'b1);

    // R10 sleep and enable
    single_i = 1'b0; flen_i = 3'd0; isel_i = 2'd0; osel_i = 2'd1; raw_i = 1'b1;
    tick(8);
    sleep_i = 1'b1;
    tick(1);
    chk("R10 sleep clears", result_o, 1'b0);
    chk("R10/R6 sleep pin low", pin_o, 1'b0);
    raw_i = 1'b0; tick(2); raw_i = 1'b1;
    count_irq(6, n);
    chk_cnt("R10 sleep irq", n, 0);
    stdby_run_i = 1'b1;
    tick(3);
    chk("R10 run during sleep", result_o, 1'b1);
    sleep_i = 1'b0; stdby_run_i = 1'b0; enable_i = 1'b0;
    tick(1);
    chk("R10 disable clears", result_o, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule